// File: doc/BRIEF.md
# Manchester Bit-Timing Recovery with Acknowledge Resynchronisation

This block recovers bit timing for a slave on a single-wire Manchester bus that carries no clock. When a command begins, the surrounding logic pulses `hdr_start`. The block then times a fixed preamble of alternating bits on its fast local clock and divides the total by a power-of-two bit count, which is only a shift. The quotient is the bit period, and it governs the rest of the command. From then on, each bit has a window centred on the point where its mid-bit transition should fall. The direction of the transition found in that window gives the bit value. Transitions at bit boundaries fall outside the window and are ignored.

The timing reference is held fixed between acknowledge bits. The framing logic raises `ack_slot` for the bit position that carries the master's acknowledge. A rising mid-bit edge in that slot is a MAK: the phase is re-anchored on that edge, and the period is replaced by the measured distance from the previous mid-bit edge. That new value is limited twice, once per update and once against the preamble value. A falling edge in that slot is a NoMAK and ends the command. If no transition lands in a window, the block flags a missed edge and ignores the line until the next `hdr_start`. The line passes through a two-flop synchroniser. Every edge therefore carries the same latency, so the measured intervals are unaffected by it.

Top module: `manch_bit_timer`

## Requirements
- R1: While reset is held, and directly after it, `bit_vld`, `ack_mak`, `ack_nomak` and `miss_err` are low and `bit_period` is 0.
- R2: After `hdr_start`, the preamble is 2^HDR_LOG2+1 alternating bits, starting with 0, on a line that idles high. `bit_period` becomes the clock count from the first falling edge to the 2^HDR_LOG2-th edge after it, divided by 2^HDR_LOG2.
- R3: Each tracked bit yields one `bit_vld` pulse. `bit_val` is 1 for a rising mid-bit edge and 0 for a falling one, and boundary edges produce no pulse.
- R4: A mid-bit edge is accepted anywhere within ±`bit_period`/4 of its expected point. Outside acknowledge slots, accepting an edge does not move the expected grid.
- R5: A rising edge in an acknowledge slot raises `ack_mak` together with `bit_vld` and `bit_val`=1. It re-anchors the phase on that edge and sets `bit_period` to the measured mid-to-mid interval, changed by at most `bit_period`>>STEP_SH from the previous value.
- R6: After any MAK update, `bit_period` stays within ±(preamble period >> DEV_SH) of the preamble period.
- R7: `bit_period` changes only at the end of a preamble or at a MAK.
- R8: If no edge is accepted by the end of a window, `miss_err` pulses once with no `bit_vld`, and all later line activity is ignored until `hdr_start`.
- R9: A falling edge in an acknowledge slot raises `ack_nomak` together with `bit_vld` and `bit_val`=0, and the block then ignores the line until `hdr_start`.
- R10: `hdr_start` restarts preamble measurement at any time. The next preamble alone sets the period, and earlier MAK corrections are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Asynchronous bus data line |
| hdr_start | input | 1 | Pulse: begin measuring a new preamble |
| ack_slot | input | 1 | High while the current bit is the acknowledge position |
| bit_vld | output | 1 | One-cycle strobe for a recovered bit |
| bit_val | output | 1 | Value of the recovered bit |
| ack_mak | output | 1 | Strobe: acknowledge slot held a MAK |
| ack_nomak | output | 1 | Strobe: acknowledge slot held a NoMAK |
| miss_err | output | 1 | Strobe: expected mid-bit edge absent |
| bit_period | output | W | Current bit period in clock cycles |

## Verification
The hardest situation to reach is a MAK whose measured interval goes beyond both limits at once, because the period it exposes depends on the drift already built up in earlier bytes. The stimulus first applies an accepted, unclamped correction. It then places the next acknowledge edge late enough that the per-update limit clips the value, and the total-deviation limit clips it further. A downward case does the same. The driver schedules every transition by its distance from the previous mid-bit edge, so each measured interval is known exactly. A data bit placed late inside its window, followed by one placed back on the grid, shows that ordinary bits leave the phase alone.

// File: rtl/manch_bit_timer.sv
module manch_bit_timer #(
  parameter int W        = 12,
  parameter int HDR_LOG2 = 3,
  parameter int STEP_SH  = 3,
  parameter int DEV_SH   = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_in,
  input  logic         hdr_start,
  input  logic         ack_slot,
  output logic         bit_vld,
  output logic         bit_val,
  output logic         ack_mak,
  output logic         ack_nomak,
  output logic         miss_err,
  output logic [W-1:0] bit_period
);
  localparam int CW = W + HDR_LOG2;

  typedef enum logic [1:0] {S_IDLE, S_HUNT, S_HDR, S_TRACK} st_t;
  st_t st;

  logic                s1, s2, s3;
  logic [CW-1:0]       cnt;
  logic [HDR_LOG2-1:0] ecnt;
  logic [W-1:0]        ref_per, ph, prev_ph;
  logic                got;

  logic          edge_s, rise, in_win, win_end, accept;
  logic [W-1:0]  qtr, win_lo, step, dev, lo_a, lo_b, lo, hi_sat, newp, ph_wrap, hdr_per;
  logic [W:0]    win_hi, ivl, hi_a, hi_b, hi;

  assign edge_s  = s2 ^ s3;
  assign rise    = s2 & ~s3;
  assign qtr     = bit_period >> 2;
  assign win_lo  = bit_period - qtr;
  assign win_hi  = {1'b0, bit_period} + {1'b0, qtr};
  assign in_win  = ({1'b0, ph} >= {1'b0, win_lo}) && ({1'b0, ph} <= win_hi);
  assign win_end = ({1'b0, ph} == win_hi);
  assign accept  = (st == S_TRACK) && edge_s && in_win && !got;
  assign ph_wrap = ph + 1'b1 - bit_period;
  assign hdr_per = W'(cnt >> HDR_LOG2);

  assign ivl    = {1'b0, bit_period} + {1'b0, ph} - {1'b0, prev_ph};
  assign step   = bit_period >> STEP_SH;
  assign dev    = ref_per >> DEV_SH;
  assign lo_a   = bit_period - step;
  assign lo_b   = ref_per - dev;
  assign lo     = (lo_a > lo_b) ? lo_a : lo_b;
  assign hi_a   = {1'b0, bit_period} + {1'b0, step};
  assign hi_b   = {1'b0, ref_per} + {1'b0, dev};
  assign hi     = (hi_a < hi_b) ? hi_a : hi_b;
  assign hi_sat = hi[W] ? {W{1'b1}} : hi[W-1:0];
  assign newp   = (ivl < {1'b0, lo}) ? lo : (ivl > hi) ? hi_sat : ivl[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      st <= S_IDLE;
      cnt <= '0; ecnt <= '0;
      ref_per <= '0; bit_period <= '0; ph <= '0; prev_ph <= '0;
      got <= 1'b0;
      bit_vld <= 1'b0; bit_val <= 1'b0; ack_mak <= 1'b0; ack_nomak <= 1'b0; miss_err <= 1'b0;
    end else begin
      s1 <= line_in; s2 <= s1; s3 <= s2;
      bit_vld <= 1'b0; ack_mak <= 1'b0; ack_nomak <= 1'b0; miss_err <= 1'b0;
      if (hdr_start) begin
        st  <= S_HUNT;
        got <= 1'b0;
      end else begin
        case (st)
          S_HUNT: if (edge_s && !rise) begin
            st <= S_HDR; cnt <= CW'(1); ecnt <= '0;
          end
          S_HDR: begin
            cnt <= cnt + 1'b1;
            if (edge_s) begin
              ecnt <= ecnt + 1'b1;
              if (&ecnt) begin
                bit_period <= hdr_per; ref_per <= hdr_per; prev_ph <= hdr_per;
                ph <= W'(1); got <= 1'b0; st <= S_TRACK;
              end
            end
          end
          S_TRACK: begin
            ph <= ph + 1'b1;
            if (accept) begin
              bit_vld <= 1'b1;
              bit_val <= rise;
              if (ack_slot) begin
                if (rise) begin
                  ack_mak <= 1'b1; bit_period <= newp; prev_ph <= newp; ph <= W'(1);
                end else begin
                  ack_nomak <= 1'b1; st <= S_IDLE;
                end
              end else begin
                prev_ph <= ph;
                got     <= !win_end;
                if (win_end) ph <= ph_wrap;
              end
            end else if (win_end) begin
              if (got) begin
                got <= 1'b0; ph <= ph_wrap;
              end else begin
                miss_err <= 1'b1; st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module manch_bit_timer_chk #(parameter int W = 12) (
  input logic         clk,
  input logic         rst_n,
  input logic         bit_vld,
  input logic         bit_val,
  input logic         ack_mak,
  input logic         ack_nomak,
  input logic         miss_err,
  input logic [W-1:0] bit_period
);
  // R5
  mak_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_mak |-> (bit_vld && bit_val));
  // R9
  nomak_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_nomak |-> (bit_vld && !bit_val && !ack_mak));
  // R8
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err |-> !bit_vld);
  // R8
  miss_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err |=> (!bit_vld && !miss_err));
  // R7
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !ack_mak) |-> $stable(bit_period));
endmodule

bind manch_bit_timer manch_bit_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
  .ack_mak(ack_mak), .ack_nomak(ack_nomak), .miss_err(miss_err),
  .bit_period(bit_period));

// File: tb/sim_manch_bit_timer.sv
`timescale 1ns/1ps
module sim_manch_bit_timer;
  localparam int W = 12;
  logic clk = 1'b0, rst_n = 1'b0, line = 1'b1, hdr = 1'b0, ack = 1'b0;
  logic bit_vld, bit_val, ack_mak, ack_nomak, miss_err;
  logic [W-1:0] bit_period;
  int vectors = 0, fails = 0;
  bit done = 1'b0;
  logic [2:0] q[$];

  always #4 clk = ~clk;

  manch_bit_timer #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line), .hdr_start(hdr), .ack_slot(ack),
    .bit_vld(bit_vld), .bit_val(bit_val), .ack_mak(ack_mak), .ack_nomak(ack_nomak),
    .miss_err(miss_err), .bit_period(bit_period));

  task automatic chk(string r, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // gap = cycles from previous mid-bit edge to this bit's mid-bit edge
  task automatic bitx(logic v, int gap, logic a, logic mid);
    idle(4);
    ack = a;
    idle(gap / 2 - 4);
    line = ~v;
    idle(gap - gap / 2);
    if (mid) line = v;
  endtask

  task automatic dbit(logic v, int gap);
    q.push_back({2'd0, v});
    bitx(v, gap, 1'b0, 1'b1);
  endtask

  task automatic bits7(logic [7:0] b, int gap);
    for (int i = 6; i >= 0; i--) dbit(b[i], gap);
  endtask

  task automatic mak(int gap);
    q.push_back(3'b011);
    bitx(1'b1, gap, 1'b1, 1'b1);
  endtask

  task automatic nomak(int gap);
    q.push_back(3'b100);
    bitx(1'b0, gap, 1'b1, 1'b1);
  endtask

  task automatic header(int h);
    line = 1'b1;
    idle(4);
    hdr = 1'b1;
    idle(1);
    hdr = 1'b0;
    for (int i = 0; i < 9; i++) bitx(i[0], 2 * h, 1'b0, 1'b1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin : mon
    logic [2:0] k, e;
    if (rst_n && (bit_vld || miss_err)) begin
      k = miss_err ? 3'b110 : ack_mak ? {2'd1, bit_val} : ack_nomak ? {2'd2, bit_val} : {2'd0, bit_val};
      vectors++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R8 or R9 unexpected output actual %0d expected none", k);
      end else begin
        e = q.pop_front();
        if (k !== e) begin
          fails++;
          case (e[2:1])
            2'd0: $display("FAIL R3 bit actual %0d expected %0d", k, e);
            2'd1: $display("FAIL R5 mak actual %0d expected %0d", k, e);
            2'd2: $display("FAIL R9 nomak actual %0d expected %0d", k, e);
            default: $display("FAIL R8 miss actual %0d expected %0d", k, e);
          endcase
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle(5);
    // R1 reset state
    chk("R1 vld", bit_vld, 0);
    chk("R1 flags", {ack_mak, ack_nomak, miss_err}, 0);
    chk("R1 period", bit_period, 0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 period after reset", bit_period, 0);

    // command A: period 40
    header(20);
    dbit(1'b1, 40);
    chk("R2 period", bit_period, 40);
    bits7(8'hA5, 40);
    mak(42);
    dbit(1'b0, 42);
    chk("R5 period update", bit_period, 42);
    dbit(1'b1, 42);
    dbit(1'b1, 50);      // R4 late edge inside window
    dbit(1'b0, 34);      // back on the unchanged grid
    dbit(1'b1, 42);
    dbit(1'b0, 42);
    dbit(1'b0, 42);
    dbit(1'b1, 42);
    chk("R7 period held over data", bit_period, 42);
    mak(50);
    dbit(1'b1, 45);
    chk("R6 clamped to upper deviation", bit_period, 45);
    bits7(8'h5A, 45);
    mak(45);
    dbit(1'b0, 45);
    chk("R6 stays at limit", bit_period, 45);
    bits7(8'hC3, 45);
    nomak(45);
    bitx(1'b1, 45, 1'b0, 1'b1);
    bitx(1'b0, 45, 1'b0, 1'b1);
    bitx(1'b1, 45, 1'b0, 1'b1);
    idle(10);
    chk("R9 no output after nomak", q.size(), 0);

    // command B: period 26, missed edge
    header(13);
    dbit(1'b0, 26);
    chk("R10 period from new header", bit_period, 26);
    dbit(1'b1, 26);
    dbit(1'b1, 26);
    dbit(1'b0, 26);
    q.push_back(3'b110);
    bitx(1'b1, 26, 1'b0, 1'b0);
    bitx(1'b0, 26, 1'b0, 1'b1);
    bitx(1'b1, 26, 1'b0, 1'b1);
    bitx(1'b0, 26, 1'b0, 1'b1);
    idle(10);
    chk("R8 queue drained after miss", q.size(), 0);
    chk("R8 period kept", bit_period, 26);

    // command C: downward correction and lower clamp
    header(20);
    dbit(1'b1, 40);
    chk("R2 second header", bit_period, 40);
    bits7(8'h0F, 40);
    mak(36);
    dbit(1'b0, 36);
    chk("R5 downward update", bit_period, 36);
    bits7(8'h96, 36);
    mak(30);
    dbit(1'b1, 35);
    chk("R6 clamped to lower deviation", bit_period, 35);
    bits7(8'h3C, 35);
    nomak(35);
    idle(20);
    chk("R9 final queue", q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule